// File: doc/BRIEF.md
# Dual Prescaled Counter/Timer

This block holds two 8-bit down-counters, and a 6-bit prescaler sits in front of each one. The prescalers run from an internal tick, which is the system clock divided by four. Timer 1 can run from that tick or from an external input pin instead. A five-register file on a simple synchronous bus sets every initial value, count mode, clock source and pin mode. Software loads and enables each timer through the mode register. It can read back the live count of either counter at any time.

The input pin can work as a clock for timer 1. It can also work as a gate that lets timer 1 count only while the pin is high. In the two trigger modes, a falling edge on the pin loads timer 1 and starts it. The non-retriggerable trigger ignores edges while a count is in progress. The retriggerable trigger restarts the count on every falling edge. Each timer gives a one-cycle end-of-count pulse for an interrupt. A single output pin shows one of three sources: timer 0's toggle, timer 1's toggle or the internal clock.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After reset both timers are stopped, the mode register (address 0) reads 0x00, `out_pin` is low and both `eoc` bits are low.
- R2: A counter initial value (timer 0 at address 1, timer 1 at address 3) of 0x00 counts 256. Reading a counter address returns the live count.
- R3: The internal tick is one system clock in four. A prescaler modulo (bits 7:2 of address 2 or 4) of 0 means 64. In continuous mode, timer 0 pulses `eoc[0]` every 4 × modulo × count clocks.
- R4: Each end-of-count pulse lasts exactly one clock.
- R5: When prescaler bit 0 is 1, the timer reloads at terminal count and keeps counting. When bit 0 is 0, the timer gives one pulse and then holds its count at 0.
- R6: Mode register layout: bit 0 is the load strobe for timer 0, bit 1 enables timer 0, bit 2 is the load strobe for timer 1, bit 3 enables timer 1, bits 5:4 select the input pin mode and bits 7:6 select the output pin source. Writing 1 to a load bit copies the initial values into the working counter and prescaler at that write's clock edge. Writing 0 to a load bit changes nothing. Load bits always read as 0.
- R7: While a timer's enable bit is 0, its count does not change.
- R8: Timer 1 takes its clock from bit 1 of address 4: 1 selects the internal tick and 0 selects the input pin. With the pin selected and the input mode at 00, timer 1 counts one prescaler step per rising edge of the pin, after a two-flop synchroniser.
- R9: In input mode 01 (gate), timer 1 counts internal ticks only while the pin is high.
- R10: In input mode 10, a falling edge on the pin loads timer 1 and starts it. Timer 1 does not count before that edge. Further edges are ignored until the count ends.
- R11: In input mode 11, every falling edge on the pin reloads timer 1 and restarts it.
- R12: The output pin source codes are 00 for constant low, 01 for the timer 0 toggle, 10 for the timer 1 toggle and 11 for the internal clock (high two clocks out of every four).
- R13: Each timer's toggle flips on every end-of-count. Writing that timer's load bit forces the toggle low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_pin | input | 1 | Timer input pin (clock, gate or trigger) |
| out_pin | output | 1 | Selected timer toggle or internal clock |
| eoc | output | 2 | End-of-count pulses, bit 0 for timer 0 and bit 1 for timer 1 |

## Verification
A register write takes effect at the clock edge that samples it. A count read is combinational, so the bench reads back on the falling edge after the write. An end-of-count pulse is visible in the clock after the terminal step. The bench samples it on falling edges and checks that it has gone low one clock later. The toggle pin follows the pulse by one more clock. A change on `ext_pin` acts on the third clock edge after the change, so the pin checks allow a few cycles of settling before they read. The internal divider runs freely from reset, so the start of a count depends on the divider's phase. For that reason periods are measured between two pulses, and the waits for count reads are kept well clear of the 256-clock step of a 64 prescaler.

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer #(
  parameter int CW = 8,
  parameter int PW = 6,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ext_pin,
  output logic          out_pin,
  output logic [1:0]    eoc
);

  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_CNT0 = AW'(1);
  localparam logic [AW-1:0] A_PRE0 = AW'(2);
  localparam logic [AW-1:0] A_CNT1 = AW'(3);
  localparam logic [AW-1:0] A_PRE1 = AW'(4);

  logic [1:0]             en, in_mode, out_mode;
  logic [1:0][CW-1:0]     init, cnt;
  logic [1:0][PW-1:0]     pmod, ps;
  logic [1:0]             cont, done, tog, tick, ld_wr, ld, active;
  logic                   src1, go1;
  logic [1:0]             div;
  logic [2:0]             sp;

  wire mode_wr  = bus_wr && (bus_addr == A_MODE);
  wire int_tick = (div == 2'd3);
  wire pin_q    = sp[1];
  wire rise     = sp[1] & ~sp[2];
  wire fall     = ~sp[1] & sp[2];
  wire trig_md  = in_mode[1];
  wire ext_clk  = (in_mode == 2'b00) && !src1;
  wire busy1    = go1 && !done[1];
  wire trig_ld  = en[1] && trig_md && fall && (in_mode[0] || !busy1);
  wire t1_tick  = ext_clk ? rise : (int_tick && (in_mode != 2'b01 || pin_q));

  assign ld_wr  = mode_wr ? {bus_wdata[2], bus_wdata[0]} : 2'b00;
  assign ld     = {ld_wr[1] | trig_ld, ld_wr[0]};
  assign tick   = {t1_tick, int_tick};
  assign active = {en[1] && !done[1] && (!trig_md || go1), en[0] && !done[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; in_mode <= '0; out_mode <= '0;
      init <= '0; pmod <= '0; cont <= '0; src1 <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: begin
          en       <= {bus_wdata[3], bus_wdata[1]};
          in_mode  <= bus_wdata[5:4];
          out_mode <= bus_wdata[7:6];
        end
        A_CNT0: init[0] <= bus_wdata;
        A_PRE0: begin
          pmod[0] <= bus_wdata[PW+1:2];
          cont[0] <= bus_wdata[0];
        end
        A_CNT1: init[1] <= bus_wdata;
        A_PRE1: begin
          pmod[1] <= bus_wdata[PW+1:2];
          src1    <= bus_wdata[1];
          cont[1] <= bus_wdata[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div <= '0; sp <= '0; go1 <= 1'b0;
    end else begin
      div <= div + 2'd1;
      sp  <= {sp[1:0], ext_pin};
      if (ld_wr[1])     go1 <= 1'b0;
      else if (trig_ld) go1 <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; ps <= '0; done <= '0; eoc <= '0; tog <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        eoc[i] <= 1'b0;
        if (ld[i]) begin
          cnt[i]  <= init[i];
          ps[i]   <= pmod[i];
          done[i] <= 1'b0;
        end else if (active[i] && tick[i]) begin
          if (ps[i] == PW'(1)) begin
            ps[i] <= pmod[i];
            if (cnt[i] == CW'(1)) begin
              eoc[i] <= 1'b1;
              if (cont[i]) cnt[i] <= init[i];
              else begin
                cnt[i]  <= '0;
                done[i] <= 1'b1;
              end
            end else begin
              cnt[i] <= cnt[i] - CW'(1);
            end
          end else begin
            ps[i] <= ps[i] - PW'(1);
          end
        end
        if (ld_wr[i])    tog[i] <= 1'b0;
        else if (eoc[i]) tog[i] <= ~tog[i];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = CW'({out_mode, in_mode, en[1], 1'b0, en[0], 1'b0});
      A_CNT0:  bus_rdata = cnt[0];
      A_CNT1:  bus_rdata = cnt[1];
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    case (out_mode)
      2'b01:   out_pin = tog[0];
      2'b10:   out_pin = tog[1];
      2'b11:   out_pin = div[1];
      default: out_pin = 1'b0;
    endcase
  end

  // R4
  eoc0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) eoc[0] |=> !eoc[0]);
  // R4
  eoc1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) eoc[1] |=> !eoc[1]);
  // R6
  load0_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_wr[0] |=> cnt[0] == $past(init[0]));
  // R7
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n) (!en[0] && !ld_wr[0]) |=> $stable(cnt[0]));
  // R5
  single0_chk: assert property (@(posedge clk) disable iff (!rst_n) (eoc[0] && !$past(cont[0])) |-> (cnt[0] == '0 && done[0]));
  // R13
  tog0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_wr[0] |=> !tog[0]);
  // R11
  retrig_chk: assert property (@(posedge clk) disable iff (!rst_n) trig_ld |=> cnt[1] == $past(init[1]));

endmodule

// File: tb/tb_dual_prescaled_timer.sv
module tb_dual_prescaled_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0;
  logic       out_pin;
  logic [1:0] eoc;

  int cyc = 0, e0n = 0, e1n = 0, nchk = 0, nfail = 0;
  bit finished = 1'b0;

  dual_prescaled_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .out_pin(out_pin), .eoc(eoc)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (eoc[0]) e0n <= e0n + 1;
    if (eoc[1]) e1n <= e1n + 1;
  end

  // {prescale modulo, count, expected period in clocks}
  localparam logic [31:0] VEC [7] = '{
    {6'd1, 8'd1,  18'd4},
    {6'd2, 8'd3,  18'd24},
    {6'd5, 8'd10, 18'd200},
    {6'd0, 8'd1,  18'd256},
    {6'd1, 8'd0,  18'd1024},
    {6'd3, 8'd5,  18'd60},
    {6'd7, 8'd2,  18'd56}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic wait_eoc(input int idx, output int t);
    t = -1;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (eoc[idx]) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_pulse();
    ext_pin = 1'b1; idle(3);
    ext_pin = 1'b0; idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int v, v2, t1, t2, s, ones;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 mode reads zero", v, 0);
    chk("R1 out_pin low", int'(out_pin), 0);
    chk("R1 eoc low", int'(eoc), 0);

    // R3 R2 period table for timer 0 in continuous mode
    foreach (VEC[k]) begin
      wr(3'd2, {VEC[k][31:26], 2'b01});
      wr(3'd1, VEC[k][25:18]);
      wr(3'd0, 8'h03);
      wait_eoc(0, t1);
      @(negedge clk);
      chk("R4 pulse one clock", int'(eoc[0]), 0);
      wait_eoc(0, t2);
      chk("R3 R2 period", t2 - t1, int'(VEC[k][17:0]));
      wr(3'd0, 8'h00);
    end

    // R6 load without enable, load bits read 0
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h21);
    wr(3'd0, 8'h01);
    rd(3'd1, v); chk("R6 load copies initial", v, 8'h21);
    rd(3'd0, v); chk("R6 load bits read 0", v, 0);
    wr(3'd1, 8'h05);
    rd(3'd1, v); chk("R2 read gives live count", v, 8'h21);
    wr(3'd0, 8'h02);
    idle(300);
    rd(3'd1, v); chk("R6 zero load bit no reload", v, 8'h20);

    // R7 disable holds count
    wr(3'd0, 8'h00);
    rd(3'd1, v);
    idle(600);
    rd(3'd1, v2); chk("R7 disabled count held", v2, v);

    // R5 single pass
    wr(3'd2, 8'h04);
    wr(3'd1, 8'h03);
    s = e0n;
    wr(3'd0, 8'h03);
    idle(200);
    chk("R5 single pass one pulse", e0n - s, 1);
    rd(3'd1, v); chk("R5 single pass holds 0", v, 0);

    // R12 R13 output toggle of timer 0
    wr(3'd2, 8'h05);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h43);
    chk("R13 toggle low after load", int'(out_pin), 0);
    wait_eoc(0, t1); @(negedge clk);
    chk("R13 toggle after first eoc", int'(out_pin), 1);
    wait_eoc(0, t1); @(negedge clk);
    chk("R13 toggle after second eoc", int'(out_pin), 0);
    wait_eoc(0, t1); @(negedge clk);
    chk("R12 timer0 source shown", int'(out_pin), 1);
    wr(3'd0, 8'h43);
    chk("R13 load forces low", int'(out_pin), 0);
    wr(3'd0, 8'hC0);
    ones = 0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      ones += int'(out_pin);
    end
    chk("R12 internal clock duty", ones, 4);
    wr(3'd0, 8'h00);
    chk("R12 off is low", int'(out_pin), 0);

    // R8 external clock source for timer 1
    ext_pin = 1'b0;
    wr(3'd4, 8'h09);
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h0C);
    s = e1n;
    repeat (5) pin_pulse();
    chk("R8 no eoc before 6 edges", e1n - s, 0);
    pin_pulse();
    idle(3);
    chk("R8 eoc on 6th edge", e1n - s, 1);
    wr(3'd4, 8'h0B);
    wr(3'd0, 8'h0C);
    wait_eoc(1, t1);
    wait_eoc(1, t2);
    chk("R8 internal source period", t2 - t1, 24);

    // R9 gate
    ext_pin = 1'b0;
    wr(3'd4, 8'h07);
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h1C);
    idle(100);
    rd(3'd3, v); chk("R9 gate low holds", v, 8'h80);
    ext_pin = 1'b1;
    idle(100);
    rd(3'd3, v);
    chk("R9 gate high counts", int'(v < 8'h80 && v > 8'h60), 1);
    ext_pin = 1'b0;
    idle(5);
    rd(3'd3, v);
    idle(100);
    rd(3'd3, v2); chk("R9 gate low again holds", v2, v);

    // R10 non-retriggerable trigger
    ext_pin = 1'b1;
    idle(5);
    wr(3'd4, 8'h03);
    wr(3'd3, 8'd10);
    wr(3'd0, 8'h2C);
    idle(300);
    rd(3'd3, v); chk("R10 idle before trigger", v, 10);
    ext_pin = 1'b0;
    idle(1000);
    rd(3'd3, v); chk("R10 counting after trigger", v, 7);
    ext_pin = 1'b1; idle(10);
    ext_pin = 1'b0; idle(20);
    rd(3'd3, v); chk("R10 second edge ignored", int'(v < 10), 1);

    // R11 retriggerable trigger
    ext_pin = 1'b1;
    idle(5);
    wr(3'd0, 8'h3C);
    ext_pin = 1'b0;
    idle(600);
    rd(3'd3, v); chk("R11 counting after trigger", v, 8);
    ext_pin = 1'b1; idle(10);
    ext_pin = 1'b0; idle(40);
    rd(3'd3, v); chk("R11 edge reloads", v, 10);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule